// File: doc/BRIEF.md
# Reset and Wakeup Clock Supervisor

This block decides how a microcontroller core comes back to life after a reset or a low-power period. It watches the reset sources (power-on, low-voltage, and an external reset pin) and the wakeup interrupts. On every exit path it chooses one of two routes. One route qualifies the crystal oscillator with a counted quality check before the system clocks are released. The other skips that check because the oscillator is known to be running. When no valid oscillation appears within a timeout, the block releases the clocks anyway, in self-clock mode, so the core still starts.

The quality check looks at a stream of oscillation-detected pulses sampled on the internal reference clock. It passes once a programmable number of pulses has been seen without too long a gap between them. Every recovery sequence ends with a one-cycle clock-release strobe and a one-cycle vector-fetch strobe, issued in the same cycle. A power-on flag stays set until software clears it, so firmware can tell a cold start from a warm one.

Top module: `wake_clk_supervisor`

## Requirements
- R1: While `rst_n` is low, `int_reset` and `por_flag` are 1 and `self_clk_mode`, `clk_release` and `vec_fetch` are 0. The first clock edge with `rst_n` high starts a quality check.
- R2: The check passes once PULSE_NEED pulses have been counted. With a pulse on every edge, the end strobes appear on edge PULSE_NEED+2 after reset release, counting the release edge as edge 1, and `self_clk_mode` is 0.
- R3: GAP_LIMIT consecutive edges without a pulse set the pulse count back to zero. Pulses every 4th edge with GAP_LIMIT=4 still pass; pulses every 5th edge never pass.
- R4: If the check has not passed after CHECK_TIMEOUT cycles, the end strobes appear on edge CHECK_TIMEOUT+1 with `self_clk_mode`=1. A later passing check clears `self_clk_mode`.
- R5: `ext_rst_n` held low for EXT_MIN_W edges or fewer has no effect. Held low for EXT_MIN_W+1 edges, it drives `int_reset` to 1 from that edge on, for as long as the pin stays low.
- R6: When the external reset ends and the last check passed, the end strobes appear on the next edge with no check. If the last check timed out instead, a full check runs.
- R7: `lvr_req` high drives `int_reset` to 1 on the next edge and holds it there. A full check follows the release.
- R8: `mode_req`=2'b11 in run state enters full stop. Only `ext_irq` wakes it, and `int_irq` is ignored. The wakeup runs a full check, so with a pulse on every edge the end strobes come PULSE_NEED+2 edges after the wake edge.
- R9: `mode_req`=2'b01 (wait) or 2'b10 (pseudo-stop) enters a doze state. Either interrupt wakes it. The end strobes appear WAKE_DELAY+1 edges after the interrupt is first sampled, with no check, and `self_clk_mode` is unchanged.
- R10: `clk_release` and `vec_fetch` are high together for exactly one cycle at the end of each sequence.
- R11: A low-voltage or long external reset during a check aborts it. The check then restarts from zero after the release.
- R12: `por_flag` is cleared only by `por_clr`. Low-voltage and external resets leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal reference clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| lvr_req | input | 1 | Low-voltage reset request, active high |
| ext_rst_n | input | 1 | External reset pin, active low |
| ext_irq | input | 1 | External interrupt request |
| int_irq | input | 1 | Internal interrupt request |
| mode_req | input | 2 | Low-power request: 00 run, 01 wait, 10 pseudo-stop, 11 stop |
| osc_pulse | input | 1 | Oscillation-detected pulse, one sample per cycle |
| por_clr | input | 1 | Write-one-to-clear for the power-on flag |
| int_reset | output | 1 | Internal reset to the core |
| clk_release | output | 1 | One-cycle strobe: system clocks released |
| vec_fetch | output | 1 | One-cycle strobe: CPU starts the vector fetch |
| self_clk_mode | output | 1 | System runs on the internal self-clock |
| por_flag | output | 1 | Power-on reset has occurred |

## Verification
Each result has a fixed cycle in which it is due. A reset cause shows on `int_reset` one edge after it is sampled. A skipped check puts the strobes one edge after release. Doze recovery takes WAKE_DELAY+1 edges, a passing check with a pulse on every edge takes PULSE_NEED+2, and a timeout takes CHECK_TIMEOUT+1. The bench drives inputs on falling edges and samples one time unit after each rising edge. It counts rising edges from the release or wake edge until the strobe appears and compares that count with these figures. It then samples one edge later to confirm the strobe has dropped.

// File: rtl/wcs_pkg.sv
// Package: shared state and mode encodings for the wakeup clock supervisor.
// Assumes: the mode_req encoding below is fixed by the surrounding power controller.
package wcs_pkg;
    typedef enum logic [2:0] {
        ST_RESET   = 3'd0,
        ST_CHECK   = 3'd1,
        ST_FETCH   = 3'd2,
        ST_RUN     = 3'd3,
        ST_DOZE    = 3'd4,
        ST_STOP    = 3'd5,
        ST_RECOVER = 3'd6
    } wcs_state_e;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_WAIT  = 2'b01,
        MODE_PSTOP = 2'b10,
        MODE_STOP  = 2'b11
    } wcs_mode_e;
endpackage

// File: rtl/wcs_ext_filter.sv
// Module: external reset pin width filter.
// Reports a long reset while the pin has been sampled low on more than MIN_W
// consecutive edges. Assumes the pin is already synchronised to clk.
module wcs_ext_filter #(
    parameter int MIN_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic long_o
);
    localparam int CW = $clog2(MIN_W + 1);
    localparam logic [CW-1:0] LOW_MAX = CW'(MIN_W);

    logic [CW-1:0] low_cnt;

    // Count consecutive low samples, saturating at the minimum width.
    always_ff @(posedge clk) begin
        if (!rst_n)                low_cnt <= '0;
        else if (pin_n)            low_cnt <= '0;
        else if (low_cnt != LOW_MAX) low_cnt <= low_cnt + 1'b1;
    end

    assign long_o = !pin_n && (low_cnt == LOW_MAX);

    // R5: a long reset is only reported when the pin was low on the previous edge too.
    p_long_needs_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        long_o |-> $past(!pin_n));
endmodule

// File: rtl/wcs_qual_check.sv
// Module: oscillator quality check.
// While run is high it counts oscillation pulses and elapsed cycles. A run of
// GAP_LIMIT missing samples restarts the pulse count. pass_o rises once
// PULSE_NEED pulses are counted. timeout_o marks the last window cycle without
// a pass. Assumes the caller drops run between checks so that they all start from zero.
module wcs_qual_check #(
    parameter int PULSE_NEED = 4096,
    parameter int GAP_LIMIT  = 8,
    parameter int TIMEOUT    = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic osc_pulse,
    output logic pass_o,
    output logic timeout_o
);
    localparam int GW = $clog2(PULSE_NEED + 1);
    localparam int PW = $clog2(GAP_LIMIT + 1);
    localparam int WW = $clog2(TIMEOUT + 1);
    localparam logic [GW-1:0] GOOD_MAX = GW'(PULSE_NEED);
    localparam logic [PW-1:0] GAP_LAST = PW'(GAP_LIMIT - 1);
    localparam logic [WW-1:0] WIN_LAST = WW'(TIMEOUT - 1);

    logic [GW-1:0] good_cnt;
    logic [PW-1:0] gap_cnt;
    logic [WW-1:0] win_cnt;

    // Pulse and gap counters; cleared whenever no check is running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            good_cnt <= '0;
            gap_cnt  <= '0;
        end else if (osc_pulse) begin
            gap_cnt <= '0;
            if (good_cnt != GOOD_MAX) good_cnt <= good_cnt + 1'b1;
        end else if (gap_cnt == GAP_LAST) begin
            gap_cnt  <= '0;
            good_cnt <= '0;
        end else begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // Window counter measuring the check timeout.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)          win_cnt <= '0;
        else if (win_cnt != WIN_LAST) win_cnt <= win_cnt + 1'b1;
    end

    assign pass_o    = (good_cnt == GOOD_MAX);
    assign timeout_o = (win_cnt == WIN_LAST) && !pass_o;

    // R3: within one check the count only falls after a missing pulse.
    p_drop_after_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (good_cnt < $past(good_cnt))) |-> $past(!osc_pulse));
endmodule

// File: rtl/wake_clk_supervisor.sv
// Module: reset and wakeup clock supervisor (top).
// Sequences exit from power-on, low-voltage and external reset and from the
// wait, pseudo-stop and stop modes. It chooses between a full oscillator
// quality check and a direct release, and falls back to the self-clock on
// timeout. Assumes all inputs are synchronous to clk.
module wake_clk_supervisor #(
    parameter int PULSE_NEED    = 4096,
    parameter int GAP_LIMIT     = 8,
    parameter int CHECK_TIMEOUT = 50000,
    parameter int EXT_MIN_W     = 16,
    parameter int WAKE_DELAY    = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvr_req,
    input  logic       ext_rst_n,
    input  logic       ext_irq,
    input  logic       int_irq,
    input  logic [1:0] mode_req,
    input  logic       osc_pulse,
    input  logic       por_clr,
    output logic       int_reset,
    output logic       clk_release,
    output logic       vec_fetch,
    output logic       self_clk_mode,
    output logic       por_flag
);
    import wcs_pkg::*;

    localparam int DW = $clog2(WAKE_DELAY + 1);
    localparam logic [DW-1:0] DLY_LAST = DW'(WAKE_DELAY - 1);

    wcs_state_e    state;
    logic          need_chk;
    logic          osc_ok;
    logic          self_clk;
    logic [DW-1:0] dly_cnt;
    logic          ext_long;
    logic          chk_run;
    logic          chk_pass;
    logic          chk_timeout;

    wcs_ext_filter #(.MIN_W(EXT_MIN_W)) u_ext_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n  (ext_rst_n),
        .long_o (ext_long)
    );

    assign chk_run = (state == ST_CHECK);

    wcs_qual_check #(
        .PULSE_NEED (PULSE_NEED),
        .GAP_LIMIT  (GAP_LIMIT),
        .TIMEOUT    (CHECK_TIMEOUT)
    ) u_qual_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (chk_run),
        .osc_pulse (osc_pulse),
        .pass_o    (chk_pass),
        .timeout_o (chk_timeout)
    );

    // Main sequencer: reset causes first, then per-state recovery steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_RESET;
            need_chk <= 1'b1;
            osc_ok   <= 1'b0;
            self_clk <= 1'b0;
            dly_cnt  <= '0;
        end else if (lvr_req) begin
            state    <= ST_RESET;
            need_chk <= 1'b1;
            osc_ok   <= 1'b0;
        end else if (ext_long) begin
            state <= ST_RESET;
            if (!osc_ok) need_chk <= 1'b1;
        end else begin
            case (state)
                ST_RESET: begin
                    state    <= need_chk ? ST_CHECK : ST_FETCH;
                    need_chk <= 1'b0;
                end
                ST_CHECK: begin
                    if (chk_pass) begin
                        state    <= ST_FETCH;
                        osc_ok   <= 1'b1;
                        self_clk <= 1'b0;
                    end else if (chk_timeout) begin
                        state    <= ST_FETCH;
                        self_clk <= 1'b1;
                    end
                end
                ST_FETCH: state <= ST_RUN;
                ST_RUN: begin
                    case (wcs_mode_e'(mode_req))
                        MODE_STOP: begin
                            state  <= ST_STOP;
                            osc_ok <= 1'b0;
                        end
                        MODE_WAIT, MODE_PSTOP: state <= ST_DOZE;
                        default: state <= ST_RUN;
                    endcase
                end
                ST_DOZE: begin
                    dly_cnt <= '0;
                    if (ext_irq || int_irq) state <= ST_RECOVER;
                end
                ST_RECOVER: begin
                    if (dly_cnt == DLY_LAST) state <= ST_FETCH;
                    else                     dly_cnt <= dly_cnt + 1'b1;
                end
                ST_STOP: begin
                    if (ext_irq) state <= ST_CHECK;
                end
                default: state <= ST_RESET;
            endcase
        end
    end

    // Power-on flag: set by power-on reset, cleared only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       por_flag <= 1'b1;
        else if (por_clr) por_flag <= 1'b0;
    end

    assign int_reset     = (state == ST_RESET);
    assign clk_release   = (state == ST_FETCH);
    assign vec_fetch     = (state == ST_FETCH);
    assign self_clk_mode = self_clk;

    // R10: the fetch strobe never lasts two cycles.
    p_fetch_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vec_fetch |=> !vec_fetch);

    // R7: after power-on, internal reset only rises on a low-voltage or long external reset.
    p_reset_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_reset) |-> $past(lvr_req || ext_long));

    // R12: the power-on flag only falls after a clear request.
    p_por_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por_flag) |-> $past(por_clr));

    // R4: self-clock mode is only entered from a check timeout.
    p_self_clk_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(self_clk_mode) |-> $past(chk_timeout));

    // R9: doze recovery leaves the clock source unchanged.
    p_doze_keeps_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_fetch && $past(state == ST_RECOVER)) |-> $stable(self_clk_mode));
endmodule

// File: tb/wake_clk_supervisor_bench.sv
// Bench: table of power-on scenarios, followed by directed tests for the
// reset, wakeup and abort paths.
module wake_clk_supervisor_bench;
    localparam int N  = 16;
    localparam int G  = 4;
    localparam int T  = 200;
    localparam int EW = 8;
    localparam int D  = 10;

    // Table: oscillator pulse period (0 = none), expected self-clock, expected edge (0 = any).
    localparam int NV = 5;
    localparam int PER[NV]   = '{1, 2, 4, 5, 0};
    localparam int XSELF[NV] = '{0, 0, 0, 1, 1};
    localparam int XEDGE[NV] = '{N + 2, 0, 0, T + 1, T + 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lvr_req = 1'b0;
    logic ext_rst_n = 1'b1;
    logic ext_irq = 1'b0;
    logic int_irq = 1'b0;
    logic [1:0] mode_req = 2'b00;
    logic osc_pulse = 1'b0;
    logic por_clr = 1'b0;
    logic int_reset, clk_release, vec_fetch, self_clk_mode, por_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wake_clk_supervisor #(
        .PULSE_NEED (N),
        .GAP_LIMIT  (G),
        .CHECK_TIMEOUT (T),
        .EXT_MIN_W  (EW),
        .WAKE_DELAY (D)
    ) u_wake_clk_supervisor (
        .clk (clk), .rst_n (rst_n), .lvr_req (lvr_req), .ext_rst_n (ext_rst_n),
        .ext_irq (ext_irq), .int_irq (int_irq), .mode_req (mode_req),
        .osc_pulse (osc_pulse), .por_clr (por_clr), .int_reset (int_reset),
        .clk_release (clk_release), .vec_fetch (vec_fetch),
        .self_clk_mode (self_clk_mode), .por_flag (por_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Called at a falling edge; drives pulses and counts edges until vec_fetch.
    task automatic run_check(input int period, output int edges);
        edges = 0;
        for (int i = 0; i < T + 20; i++) begin
            osc_pulse = (period != 0) && (i % period == 0);
            step();
            if (vec_fetch) begin
                edges = i + 1;
                break;
            end
            @(negedge clk);
        end
        osc_pulse = 1'b0;
    endtask

    // Counts edges until vec_fetch without driving pulses.
    task automatic wait_fetch(output int edges);
        edges = 0;
        for (int i = 0; i < T + 20; i++) begin
            step();
            if (vec_fetch) begin
                edges = i + 1;
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int e;
        int bad;
        // Table walk: power-on reset followed by a check under each pulse pattern.
        for (int k = 0; k < NV; k++) begin
            @(negedge clk); rst_n = 1'b0;
            repeat (3) step();
            chk("R1 int_reset in reset", int'(int_reset), 1);
            chk("R1 por_flag in reset", int'(por_flag), 1);
            chk("R1 self_clk in reset", int'(self_clk_mode), 0);
            chk("R1 vec_fetch in reset", int'(vec_fetch), 0);
            @(negedge clk); rst_n = 1'b1;
            run_check(PER[k], e);
            if (XEDGE[k] != 0) chk("R2/R3/R4 fetch edge", e, XEDGE[k]);
            else chk("R3 check passed in window", int'(e > 0 && e <= T), 1);
            chk("R4 self_clk after check", int'(self_clk_mode), XSELF[k]);
            chk("R10 clk_release with fetch", int'(clk_release), 1);
            step();
            chk("R10 fetch one cycle", int'(vec_fetch), 0);
            chk("R10 release one cycle", int'(clk_release), 0);
        end

        // R6: external reset after a timed-out check runs a full check; R4 clears self-clock.
        @(negedge clk); ext_rst_n = 1'b0;
        repeat (EW + 1) step();
        chk("R5 long ext reset", int'(int_reset), 1);
        @(negedge clk); ext_rst_n = 1'b1;
        run_check(1, e);
        chk("R6 check after self-clock", e, N + 2);
        chk("R4 self_clk cleared by pass", int'(self_clk_mode), 0);
        step();

        // R5: a pulse of exactly the minimum width is ignored.
        bad = 0;
        @(negedge clk); ext_rst_n = 1'b0;
        for (int i = 0; i < EW; i++) begin
            step();
            if (int_reset || vec_fetch) bad = 1;
        end
        @(negedge clk); ext_rst_n = 1'b1;
        step();
        chk("R5 short pulse ignored", bad | int'(int_reset) | int'(vec_fetch), 0);

        // R5/R6: a long pulse after a passed check gives a direct release.
        @(negedge clk); ext_rst_n = 1'b0;
        repeat (EW) step();
        chk("R5 no reset at min width", int'(int_reset), 0);
        step();
        chk("R5 reset one edge later", int'(int_reset), 1);
        @(negedge clk); ext_rst_n = 1'b1;
        step();
        chk("R6 direct fetch after ext reset", int'(vec_fetch), 1);
        step();
        chk("R10 direct fetch one cycle", int'(vec_fetch), 0);
        chk("R12 por_flag kept by ext reset", int'(por_flag), 1);

        // R12: software clear.
        @(negedge clk); por_clr = 1'b1;
        step();
        @(negedge clk); por_clr = 1'b0;
        chk("R12 por_flag cleared", int'(por_flag), 0);

        // R7: low-voltage reset asserts and holds, then a full check follows.
        @(negedge clk); lvr_req = 1'b1;
        step();
        chk("R7 lvr reset next edge", int'(int_reset), 1);
        step();
        chk("R7 lvr reset held", int'(int_reset), 1);
        @(negedge clk); lvr_req = 1'b0;
        run_check(1, e);
        chk("R7 check after lvr", e, N + 2);
        chk("R12 por_flag kept by lvr", int'(por_flag), 0);
        step();

        // R9: wait mode woken by the internal interrupt.
        @(negedge clk); mode_req = 2'b01;
        step();
        @(negedge clk); mode_req = 2'b00; int_irq = 1'b1;
        wait_fetch(e);
        chk("R9 wait recovery edges", e, D + 1);
        chk("R9 self_clk unchanged", int'(self_clk_mode), 0);
        @(negedge clk); int_irq = 1'b0;
        step();

        // R9: pseudo-stop woken by the external interrupt.
        @(negedge clk); mode_req = 2'b10;
        step();
        @(negedge clk); mode_req = 2'b00; ext_irq = 1'b1;
        wait_fetch(e);
        chk("R9 pseudo-stop recovery edges", e, D + 1);
        @(negedge clk); ext_irq = 1'b0;
        step();

        // R8: stop ignores the internal interrupt, wakes on external and checks.
        @(negedge clk); mode_req = 2'b11;
        step();
        @(negedge clk); mode_req = 2'b00; int_irq = 1'b1;
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            step();
            if (vec_fetch || clk_release || int_reset) bad = 1;
        end
        chk("R8 int_irq ignored in stop", bad, 0);
        @(negedge clk); int_irq = 1'b0; ext_irq = 1'b1;
        run_check(1, e);
        chk("R8 stop wake runs full check", e, N + 2);
        @(negedge clk); ext_irq = 1'b0;
        step();

        // R11: a reset during a check aborts it; the next check starts from zero.
        @(negedge clk); lvr_req = 1'b1;
        step();
        @(negedge clk); lvr_req = 1'b0;
        bad = 0;
        for (int i = 0; i < N - 4; i++) begin
            osc_pulse = 1'b1;
            step();
            if (vec_fetch) bad = 1;
            @(negedge clk);
        end
        osc_pulse = 1'b0;
        lvr_req = 1'b1;
        step();
        chk("R11 reset aborts check", int'(int_reset) | (bad << 1), 1);
        @(negedge clk); lvr_req = 1'b0;
        run_check(1, e);
        chk("R11 check restarts from zero", e, N + 2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule